// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single line that processor software is expected to toggle at regular intervals. Every change on that line, whether upward or downward, restarts an internal cycle counter. If the counter runs the full timeout without seeing a change, the active-low watchdog output drops. It stays down until the next clear event. The output is meant to feed a non-maskable interrupt. The block never resets the system by itself; a system reset on watchdog expiry only happens when the output is routed back to a manual reset input elsewhere.

The watchdog line is asynchronous. It passes through a two-flop synchroniser, and a change is recognised by comparing the last two synchronised samples. While the neighbouring reset generator reports an active reset, the counter is held at zero, so timing begins only after that reset ends. A supply-low flag overrides everything else and pulls the output low. When the flag clears, the output comes back high on the next clock edge, unless the timer has already expired.

The timeout is a parameter in clock cycles. By default it is derived from a 125 MHz clock and a 1.6 s period.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, `wd_n` reads 1 after that edge and the timer is cleared.
- R2: A rising change on `wd_in` that is applied before clock edge k clears the timer at edge k+2, so a low `wd_n` reads 1 after edge k+2.
- R3: A falling change on `wd_in` clears the timer with the same timing as a rising change.
- R4: While `rst_active` is 1 at an edge, the timer is held cleared and `wd_n` is 1 (with supply good). After `rst_active` is last seen at edge j-1, `wd_n` falls after edge j-1+WD_CYCLES if no change occurs.
- R5: If a clear event occurs at edge c and no further clear follows, `wd_n` reads 1 through edge c+WD_CYCLES-1 and 0 after edge c+WD_CYCLES (while supply is good).
- R6: Once expired, the counter saturates and does not wrap. `wd_n` stays 0 for any length of inactivity, until a clear event occurs.
- R7: `supply_low` = 1 at an edge makes `wd_n` read 0 after that edge, whatever the timer state.
- R8: `supply_low` = 0 at an edge makes `wd_n` read 1 after that edge when the timer is not expired, with no reset hold delay. If the timer is expired, `wd_n` stays 0.
- R9: A pulse on `wd_in` that is two clock periods wide is detected: both of its edges clear the timer.
- R10: A clear event on the same edge at which the counter would reach WD_CYCLES takes priority, so `wd_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_in | input | 1 | Asynchronous toggle line from software |
| rst_active | input | 1 | Reset generator is holding the system in reset |
| supply_low | input | 1 | Monitored supply is below its threshold |
| wd_n | output | 1 | Active-low watchdog output, registered |

## Verification
Every result appears at a fixed cycle count after its stimulus. A supply or reset-active change shows on `wd_n` after the next edge. A `wd_in` change clears the timer at the second edge after it, so it becomes visible at the third sample. Expiry lands exactly WD_CYCLES edges after the clear edge. The bench drives inputs and samples `wd_n` on falling edges. Directed checks count edges from the stimulus to the exact edge where a result falls due, and look one edge before it as well, so an off-by-one in either direction is caught. In the same way, the tie between a clear event and terminal count is hit on the exact edge and on one edge late. A cycle model built from these latencies is compared against `wd_n` on every cycle during the random phase.

// File: rtl/edge_wd_pkg.sv
package edge_wd_pkg;

  // Level driven on the active-low watchdog output
  typedef enum logic {
    WD_BARK = 1'b0,
    WD_OK   = 1'b1
  } wd_level_e;

  localparam int unsigned SYNC_STAGES_DEFAULT = 2;

endpackage

// File: rtl/edge_wd_sync.sv
module edge_wd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= chain_q[STAGES-1];
  end

  // Either direction of change counts as activity
  assign edge_o = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/edge_wd_timer.sv
module edge_wd_timer #(
  parameter int unsigned WD_CYCLES = 16,
  parameter int unsigned CW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt_q,
  output logic          expire_nxt
);
  localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES);

  logic [CW-1:0] cnt_d;

  // Clear wins over terminal count; saturate instead of wrapping
  always_comb begin
    if (clr)                 cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + CW'(1);
  end

  assign expire_nxt = (cnt_d == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/edge_wd_out.sv
module edge_wd_out
  import edge_wd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic expire_nxt,
  output logic wd_n
);
  wd_level_e level_q;

  always_ff @(posedge clk) begin
    if (rst)                           level_q <= WD_OK;
    else if (supply_low || expire_nxt) level_q <= WD_BARK;
    else                               level_q <= WD_OK;
  end

  assign wd_n = level_q;
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog #(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned TIMEOUT_MS = 1600,
  parameter int unsigned WD_CYCLES  = (CLK_HZ / 1000) * TIMEOUT_MS
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_in,
  input  logic rst_active,
  input  logic supply_low,
  output logic wd_n
);
  localparam int unsigned CW = $clog2(WD_CYCLES + 1);

  logic          act_edge;
  logic          clr_evt;
  logic [CW-1:0] cnt_q;
  logic          expire_nxt;

  edge_wd_sync #(
    .STAGES(edge_wd_pkg::SYNC_STAGES_DEFAULT)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (wd_in),
    .edge_o (act_edge)
  );

  assign clr_evt = act_edge | rst_active;

  edge_wd_timer #(
    .WD_CYCLES(WD_CYCLES),
    .CW       (CW)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_evt),
    .cnt_q      (cnt_q),
    .expire_nxt (expire_nxt)
  );

  edge_wd_out u_out (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .expire_nxt (expire_nxt),
    .wd_n       (wd_n)
  );
endmodule

// File: rtl/edge_watchdog_chk.sv
module edge_watchdog_chk #(
  parameter int unsigned WD_CYCLES = 16,
  parameter int unsigned CW        = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          supply_low,
  input logic          rst_active,
  input logic          clr_evt,
  input logic [CW-1:0] cnt,
  input logic          wd_n
);
  localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (wd_n && cnt == '0));

  a_r4_hold_cleared: assert property (@(posedge clk) disable iff (rst)
    (rst_active && !supply_low) |=> (wd_n && cnt == '0));

  a_r5_low_only_at_limit: assert property (@(posedge clk) disable iff (rst)
    (!wd_n && !$past(supply_low)) |-> (cnt == LIMIT));

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == LIMIT && !clr_evt) |=> (cnt == LIMIT));

  a_r7_supply_forces_low: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !wd_n);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !supply_low) |=> wd_n);
endmodule

bind edge_watchdog edge_watchdog_chk #(
  .WD_CYCLES(WD_CYCLES),
  .CW       (CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_low (supply_low),
  .rst_active (rst_active),
  .clr_evt    (clr_evt),
  .cnt        (cnt_q),
  .wd_n       (wd_n)
);

// File: tb/tb_edge_watchdog.sv
module tb_edge_watchdog;
  localparam int unsigned L = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_in = 1'b0;
  logic rst_active = 1'b0;
  logic supply_low = 1'b0;
  logic wd_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_watchdog #(.WD_CYCLES(L)) dut (
    .clk(clk), .rst(rst), .wd_in(wd_in),
    .rst_active(rst_active), .supply_low(supply_low), .wd_n(wd_n)
  );

  // Cycle model: change seen two edges late, timeout L edges after clear
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  int unsigned m_cnt = 0;
  logic m_n = 1'b1;

  function automatic int unsigned next_cnt(input int unsigned c, input logic clr);
    if (clr) return 0;
    if (c == L) return L;
    return c + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0; m_cnt <= 0; m_n <= 1'b1;
    end else begin
      h1 <= wd_in; h2 <= h1; h3 <= h2;
      m_cnt <= next_cnt(m_cnt, (h2 ^ h3) | rst_active);
      m_n <= !supply_low && (next_cnt(m_cnt, (h2 ^ h3) | rst_active) != L);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) chk(wd_n === m_n, m_n ? "R2 model" : "R5 model", int'(wd_n), int'(m_n));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_n(input string tag, input logic e);
    chk(wd_n === e, tag, int'(wd_n), int'(e));
  endtask

  task automatic count_lows(input int n, input string tag, input int exp);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (wd_n !== 1'b1) lows++;
    end
    chk(lows == exp, tag, lows, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R5: run hung, actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_n("R1 reset state", 1'b1);
    rst = 1'b0;
    tick(L - 1); expect_n("R5 one edge before timeout", 1'b1);
    tick(1);     expect_n("R5 timeout after reset", 1'b0);
    tick(3 * L); expect_n("R6 saturated, still low", 1'b0);

    // R2: rising change
    wd_in = 1'b1;
    tick(2); expect_n("R2 not yet cleared", 1'b0);
    tick(1); expect_n("R2 rising clears", 1'b1);
    tick(L - 1); expect_n("R5 high before limit", 1'b1);
    tick(1);     expect_n("R5 low at limit", 1'b0);

    // R3: falling change
    wd_in = 1'b0;
    tick(2); expect_n("R3 not yet cleared", 1'b0);
    tick(1); expect_n("R3 falling clears", 1'b1);
    tick(L - 1); expect_n("R5 high before limit", 1'b1);
    tick(1);     expect_n("R5 low at limit", 1'b0);

    // R10: clear exactly on terminal edge
    wd_in = 1'b1;
    tick(3);
    count_lows(L - 3, "R10 first window", 0);
    wd_in = 1'b0;
    count_lows(L + 2, "R10 tie keeps high", 0);
    tick(1); expect_n("R5 low after tie window", 1'b0);

    // One edge late: exactly one low sample
    wd_in = 1'b1;
    tick(3);
    count_lows(L - 2, "R5 late window", 0);
    wd_in = 1'b0;
    count_lows(L + 2, "R10 one late gives one low", 1);
    tick(5);

    // R9: two-cycle pulse
    wd_in = 1'b1;
    tick(2);
    wd_in = 1'b0;
    tick(1); expect_n("R9 pulse leading edge", 1'b1);
    tick(L + 1); expect_n("R9 trailing edge restarts timer", 1'b1);
    tick(1);     expect_n("R9 timeout from trailing edge", 1'b0);

    // R4: reset activity holds timer cleared
    rst_active = 1'b1;
    tick(1); expect_n("R4 held high", 1'b1);
    count_lows(3 * L, "R4 no expiry while held", 0);
    rst_active = 1'b0;
    tick(L - 1); expect_n("R4 timing from release", 1'b1);
    tick(1);     expect_n("R4 expiry after release", 1'b0);

    // R7 / R8
    wd_in = 1'b1;
    tick(3); expect_n("R2 clear before supply test", 1'b1);
    supply_low = 1'b1;
    tick(1); expect_n("R7 supply low forces low", 1'b0);
    tick(4); expect_n("R7 stays low", 1'b0);
    supply_low = 1'b0;
    tick(1); expect_n("R8 immediate release", 1'b1);
    tick(L); expect_n("R6 expired", 1'b0);
    supply_low = 1'b1;
    tick(2);
    supply_low = 1'b0;
    tick(1); expect_n("R8 expired stays low", 1'b0);
    wd_in = 1'b0;
    supply_low = 1'b1;
    tick(3); expect_n("R7 low despite clear", 1'b0);
    supply_low = 1'b0;
    tick(1); expect_n("R8 release after clear", 1'b1);

    // Random phase, model compared every cycle
    void'($urandom(32'd5150));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 2) wd_in = ~wd_in;
      if (supply_low) begin
        if ($urandom_range(0, 7) == 0) supply_low = 1'b0;
      end else if ($urandom_range(0, 199) == 0) supply_low = 1'b1;
      if (rst_active) begin
        if ($urandom_range(0, 9) == 0) rst_active = 1'b0;
      end else if ($urandom_range(0, 299) == 0) rst_active = 1'b1;
      tick(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule